// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block is a bank of hardware semaphores. Several processors use it to take turns on shared resources. Each processor has a small nonzero master ID and reaches the bank through its own 32-bit register port. A port has an address, a write enable, write data, read data, and a sideband that carries the master ID of the current requester. The bank holds one word register per semaphore. The low four bits of that register name the owner, and the value zero means the semaphore is free.

To claim a semaphore, a master writes its own ID into the semaphore register and then reads the register back. It holds the lock only if the owner field now equals its ID. A write with a zero owner field gives the semaphore back, and only the current owner can do this. Each release sets a per-master event bit in a status word, which software clears by writing ones to a clear register. A control word keeps one protocol-select bit. Clearing that bit selects the write-then-read-back scheme that this block implements.

Top module: `semBank`

## Requirements
- R1: After reset, every semaphore reads as free (0), the control word reads 0, and the status word reads 0.
- R2: Semaphore i is mapped at byte offset 0x08 + 4*i, for i = 0..31. A read of it returns the owner ID in bits [3:0] and zero in bits [31:4]. A read of any other address (for example 0x04, 0x88 or 0xFC) returns 0.
- R3: A write whose bits [3:0] are nonzero, sent to a free semaphore, makes those four bits its owner. Bits [31:4] of the write are ignored.
- R4: A write whose bits [3:0] are nonzero, sent to a semaphore that already has an owner, is ignored, and the earlier owner is kept.
- R5: A write whose bits [3:0] are zero frees a semaphore only when the port's sideband master ID equals the current owner. The same write from any other master is ignored.
- R6: When several ports write nonzero values to the same free semaphore in one cycle, the lowest-numbered port wins. A release and a claim of an owned semaphore in the same cycle leave it free.
- R7: The control word sits at offset 0x00 and stores only bit 0. Its other bits read as 0. When several ports write it in one cycle, the lowest-numbered port wins.
- R8: A release performed by master m sets bit m of the 16-bit status word. The status word reads at offset 0x90.
- R9: A write to offset 0x90 clears every status bit that is set in write data bits [15:0], so a write of 0xFFFF clears all of them. A status bit that is set and cleared in the same cycle ends up set.
- R10: Reads have no side effects. A cycle without writes leaves every semaphore, the control word and the status word unchanged.
- R11: A write that takes effect is visible to a read on any port in the next cycle. A read in the same cycle as the write returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | NUM_PORTS*8 | Byte address per port, port p at [p*8 +: 8] |
| busWe | input | NUM_PORTS | Write enable per port |
| busWdata | input | NUM_PORTS*32 | Write data per port |
| busMid | input | NUM_PORTS*4 | Requesting master ID per port (sideband) |
| busRdata | output | NUM_PORTS*32 | Combinational read data per port |

## Verification
The hardest case to reach is a collision inside one cycle: two ports strike the same semaphore, or a release lands together with a claim or with a status clear. Directed steps line up both ports on the same edge to cover each pairing. These include two claimants on a free semaphore, a non-owner release next to a claim, an owner release next to a rival claim, and a release next to a 0xFFFF clear. After the directed steps, a long stretch of random traffic runs over a few semaphores, a few master IDs and the control and clear registers. This keeps collisions frequent, and the behavioural model checks every read on both ports on every cycle.

// File: rtl/semBankPkg.sv
package semBankPkg;
  localparam int NUM_SEM       = 32;
  localparam int ID_W          = 4;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 8;
  localparam int WORD_W        = ADDR_W - 2;
  localparam int CTRL_WORD     = 0;
  localparam int SEM_BASE_WORD = 2;
  localparam int CLR_WORD      = 36;
  localparam int STAT_W        = 1 << ID_W;

  typedef logic [ID_W-1:0] ownerId_t;

  typedef struct packed {
    logic [NUM_SEM-1:0]           semClaim;
    logic [NUM_SEM-1:0][ID_W-1:0] claimVal;
    logic [NUM_SEM-1:0]           semFree;
    logic                         ctrlWe;
    logic                         ctrlVal;
    logic [STAT_W-1:0]            statSet;
    logic [STAT_W-1:0]            statClr;
  } semStrobe_t;
endpackage

// File: rtl/semControl.sv
module semControl
  import semBankPkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrArr,
  input  logic [NUM_PORTS-1:0]             weArr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdataArr,
  input  logic [NUM_PORTS-1:0][ID_W-1:0]   midArr,
  input  logic [NUM_SEM-1:0][ID_W-1:0]     ownerVec,
  output semStrobe_t                       strb
);
  logic [NUM_PORTS-1:0]             hitCtrl;
  logic [NUM_PORTS-1:0]             hitClr;
  logic [NUM_PORTS-1:0]             hitSem;
  logic [NUM_PORTS-1:0]             isZero;
  logic [NUM_PORTS-1:0][WORD_W-1:0] semOff;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    logic [WORD_W-1:0] wordIdx;
    assign wordIdx    = addrArr[p][ADDR_W-1:2];
    assign hitCtrl[p] = weArr[p] && (int'(wordIdx) == CTRL_WORD);
    assign hitClr[p]  = weArr[p] && (int'(wordIdx) == CLR_WORD);
    assign hitSem[p]  = weArr[p] && (int'(wordIdx) >= SEM_BASE_WORD)
                        && (int'(wordIdx) < SEM_BASE_WORD + NUM_SEM);
    assign semOff[p]  = wordIdx - WORD_W'(SEM_BASE_WORD);
    assign isZero[p]  = (wdataArr[p][ID_W-1:0] == '0);
  end

  logic [NUM_SEM-1:0]           claimHit;
  logic [NUM_SEM-1:0][ID_W-1:0] claimV;
  logic [NUM_SEM-1:0]           relHit;
  logic [NUM_SEM-1:0][STAT_W-1:0] relMask;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    always_comb begin
      claimHit[i] = 1'b0;
      claimV[i]   = '0;
      relHit[i]   = 1'b0;
      // descending scan: the lowest port is assigned last and wins
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (hitSem[p] && semOff[p] == WORD_W'(i) && !isZero[p]) begin
          claimHit[i] = 1'b1;
          claimV[i]   = wdataArr[p][ID_W-1:0];
        end
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (hitSem[p] && semOff[p] == WORD_W'(i) && isZero[p]
            && ownerVec[i] != '0 && midArr[p] == ownerVec[i]) begin
          relHit[i] = 1'b1;
        end
      end
      relMask[i] = relHit[i] ? (STAT_W'(1) << ownerVec[i]) : '0;
    end
  end

  logic              ctrlWeC;
  logic              ctrlValC;
  logic [STAT_W-1:0] clrC;
  logic [STAT_W-1:0] setC;

  always_comb begin
    ctrlWeC  = 1'b0;
    ctrlValC = 1'b0;
    clrC     = '0;
    setC     = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (hitCtrl[p]) begin
        ctrlWeC  = 1'b1;
        ctrlValC = wdataArr[p][0];
      end
      if (hitClr[p]) clrC = clrC | wdataArr[p][STAT_W-1:0];
    end
    for (int i = 0; i < NUM_SEM; i++) setC = setC | relMask[i];
  end

  always_comb begin
    for (int i = 0; i < NUM_SEM; i++) begin
      strb.semClaim[i] = claimHit[i] && (ownerVec[i] == '0);
      strb.claimVal[i] = claimV[i];
    end
    strb.semFree = relHit;
    strb.ctrlWe  = ctrlWeC;
    strb.ctrlVal = ctrlValC;
    strb.statSet = setC;
    strb.statClr = clrC;
  end
endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import semBankPkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  semStrobe_t                       strb,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrArr,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdataArr,
  output logic [NUM_SEM-1:0][ID_W-1:0]     ownerVec,
  output logic                             ctrlBit,
  output logic [STAT_W-1:0]                statusVec
);
  localparam int SEL_W = $clog2(NUM_SEM);

  logic [NUM_SEM-1:0][ID_W-1:0] ownerQ;
  logic                         ctrlQ;
  logic [STAT_W-1:0]            statQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerQ <= '0;
      ctrlQ  <= 1'b0;
      statQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_SEM; i++) begin
        if (strb.semClaim[i])     ownerQ[i] <= strb.claimVal[i];
        else if (strb.semFree[i]) ownerQ[i] <= '0;
      end
      if (strb.ctrlWe) ctrlQ <= strb.ctrlVal;
      statQ <= (statQ & ~strb.statClr) | strb.statSet;
    end
  end

  assign ownerVec  = ownerQ;
  assign ctrlBit   = ctrlQ;
  assign statusVec = statQ;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    logic [WORD_W-1:0] wordIdx;
    logic [WORD_W-1:0] off;
    assign wordIdx = addrArr[p][ADDR_W-1:2];
    assign off     = wordIdx - WORD_W'(SEM_BASE_WORD);
    always_comb begin
      rdataArr[p] = '0;
      if (int'(wordIdx) == CTRL_WORD) begin
        rdataArr[p][0] = ctrlQ;
      end else if (int'(wordIdx) == CLR_WORD) begin
        rdataArr[p][STAT_W-1:0] = statQ;
      end else if (int'(wordIdx) >= SEM_BASE_WORD
                   && int'(wordIdx) < SEM_BASE_WORD + NUM_SEM) begin
        rdataArr[p][ID_W-1:0] = ownerQ[off[SEL_W-1:0]];
      end
    end
  end
endmodule

// File: rtl/semBank.sv
module semBank
  import semBankPkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS*ADDR_W-1:0]   busAddr,
  input  logic [NUM_PORTS-1:0]          busWe,
  input  logic [NUM_PORTS*DATA_W-1:0]   busWdata,
  input  logic [NUM_PORTS*ID_W-1:0]     busMid,
  output logic [NUM_PORTS*DATA_W-1:0]   busRdata
);
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrArr;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdataArr;
  logic [NUM_PORTS-1:0][ID_W-1:0]   midArr;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdataArr;
  logic [NUM_SEM-1:0][ID_W-1:0]     ownerVec;
  logic                             ctrlBit;
  logic [STAT_W-1:0]                statusVec;
  semStrobe_t                       strb;

  assign addrArr  = busAddr;
  assign wdataArr = busWdata;
  assign midArr   = busMid;
  assign busRdata = rdataArr;

  semControl #(.NUM_PORTS(NUM_PORTS)) uCtrl (
    .addrArr (addrArr),
    .weArr   (busWe),
    .wdataArr(wdataArr),
    .midArr  (midArr),
    .ownerVec(ownerVec),
    .strb    (strb)
  );

  semDatapath #(.NUM_PORTS(NUM_PORTS)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addrArr  (addrArr),
    .rdataArr (rdataArr),
    .ownerVec (ownerVec),
    .ctrlBit  (ctrlBit),
    .statusVec(statusVec)
  );
endmodule

// File: rtl/semBankChecker.sv
module semBankChecker
  import semBankPkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_PORTS-1:0]         busWe,
  input logic [NUM_SEM-1:0][ID_W-1:0] ownerVec,
  input logic                         ctrlBit,
  input logic [STAT_W-1:0]            statusVec
);
  // R1: reset leaves everything free and clear
  p_reset_clears_r1: assert property (@(posedge clk)
    !rstN |=> (ownerVec == '0 && !ctrlBit && statusVec == '0));

  // R10: a cycle without writes changes no state
  p_read_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWe == '0) |=> ($stable(ownerVec) && $stable(ctrlBit) && $stable(statusVec)));

  // R8: a status bit rises only together with a semaphore becoming free
  p_status_needs_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & ~$past(statusVec)) != '0) |-> (ownerVec != $past(ownerVec)));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    // R4: an owned semaphore keeps its owner or becomes free, never another ID
    p_owned_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
      (ownerVec[i] != '0) |=> (ownerVec[i] == $past(ownerVec[i]) || ownerVec[i] == '0));
    // R5: an owned semaphore cannot be freed without a write
    p_release_needs_write_r5: assert property (@(posedge clk) disable iff (!rstN)
      (ownerVec[i] != '0 && busWe == '0) |=> (ownerVec[i] != '0));
  end
endmodule

bind semBank semBankChecker #(.NUM_PORTS(NUM_PORTS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .ownerVec (ownerVec),
  .ctrlBit  (ctrlBit),
  .statusVec(statusVec)
);

// File: tb/tb_semBank.sv
module tb_semBank;
  localparam int NP = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NP*8-1:0]  busAddr = '0;
  logic [NP-1:0]    busWe = '0;
  logic [NP*32-1:0] busWdata = '0;
  logic [NP*4-1:0]  busMid = '0;
  logic [NP*32-1:0] busRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int ownM[32];
  int ctrlM = 0;
  int statM = 0;

  always #5 clk = ~clk;

  semBank #(.NUM_PORTS(NP)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busMid(busMid), .busRdata(busRdata)
  );

  function automatic int modelRead(int addr);
    int w = addr >> 2;
    if (w == 0) return ctrlM;
    if (w >= 2 && w < 34) return ownM[w - 2];
    if (w == 36) return statM;
    return 0;
  endfunction

  task automatic setPort(int p, bit we, int addr, int data, int mid);
    busWe[p]          = we;
    busAddr[p*8 +: 8] = addr[7:0];
    busWdata[p*32 +: 32] = data;
    busMid[p*4 +: 4]  = mid[3:0];
  endtask

  // compare reads on both ports, update the model, cross one clock edge
  task automatic step(string tag);
    int nOwn[32];
    int nCtrl;
    int setMask = 0;
    int clr = 0;
    #1;
    for (int p = 0; p < NP; p++) begin
      int exp = modelRead(int'(busAddr[p*8 +: 8]));
      int act = int'(busRdata[p*32 +: 32]);
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s port%0d addr=%0h actual=%0h expected=%0h",
                 tag, p, busAddr[p*8 +: 8], act, exp);
      end
    end
    nCtrl = ctrlM;
    for (int s = 0; s < 32; s++) begin
      nOwn[s] = ownM[s];
      if (ownM[s] == 0) begin
        for (int p = NP - 1; p >= 0; p--)
          if (busWe[p] && int'(busAddr[p*8 +: 8]) >> 2 == s + 2 && busWdata[p*32 +: 4] != 0)
            nOwn[s] = int'(busWdata[p*32 +: 4]);
      end else begin
        for (int p = 0; p < NP; p++)
          if (busWe[p] && int'(busAddr[p*8 +: 8]) >> 2 == s + 2 && busWdata[p*32 +: 4] == 0
              && int'(busMid[p*4 +: 4]) == ownM[s]) begin
            nOwn[s] = 0;
            setMask = setMask | (1 << ownM[s]);
          end
      end
    end
    for (int p = NP - 1; p >= 0; p--) begin
      if (busWe[p] && int'(busAddr[p*8 +: 8]) >> 2 == 0) nCtrl = int'(busWdata[p*32]);
      if (busWe[p] && int'(busAddr[p*8 +: 8]) >> 2 == 36) clr = clr | int'(busWdata[p*32 +: 16]);
    end
    @(posedge clk);
    for (int s = 0; s < 32; s++) ownM[s] = nOwn[s];
    ctrlM = nCtrl;
    statM = (statM & ~clr) | setMask;
    @(negedge clk);
    busWe = '0;
  endtask

  task automatic rd2(int a0, int a1, string tag);
    setPort(0, 0, a0, 0, 1);
    setPort(1, 0, a1, 0, 2);
    step(tag);
  endtask

  task automatic wr(int p, int addr, int data, int mid, int otherAddr);
    setPort(p, 1, addr, data, mid);
    setPort(1 - p, 0, otherAddr, 0, 1);
  endtask

  initial begin
    for (int s = 0; s < 32; s++) ownM[s] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state on every register
    rd2(32'h00, 32'h90, "R1");
    for (int s = 0; s < 32; s++) rd2(8 + 4 * s, 8 + 4 * (31 - s), "R1");
    // R2: unmapped holes read zero
    rd2(32'h04, 32'h88, "R2");
    rd2(32'hFC, 32'h8C, "R2");
    // R3, R11: claim sem 5 by master 1; same-cycle read still old
    wr(0, 32'h1C, 32'h1, 1, 32'h1C); step("R11");
    rd2(32'h1C, 32'h1C, "R3");
    // R3, R2: high bits of claim ignored, upper read bits zero
    wr(1, 32'h84, 32'hFFFF_FFFA, 10, 32'h84); step("R3");
    rd2(32'h84, 32'h84, "R2");
    // R4: master 2 tries owned sem 5
    wr(1, 32'h1C, 32'h2, 2, 32'h1C); step("R4");
    rd2(32'h1C, 32'h1C, "R4");
    // R5: non-owner release ignored, owner release (0x30 => nibble 0) frees
    wr(1, 32'h1C, 32'h0, 2, 32'h1C); step("R5");
    rd2(32'h1C, 32'h90, "R5");
    wr(0, 32'h1C, 32'h30, 1, 32'h90); step("R5");
    rd2(32'h1C, 32'h90, "R8");
    // R6: two claimants on free sem 7
    setPort(0, 1, 32'h24, 3, 3); setPort(1, 1, 32'h24, 6, 6); step("R6");
    rd2(32'h24, 32'h24, "R6");
    // R6: zero write beside a claim on free sem 9
    setPort(0, 1, 32'h2C, 0, 3); setPort(1, 1, 32'h2C, 6, 6); step("R6");
    rd2(32'h2C, 32'h2C, "R6");
    // R6: owner release with rival claim on sem 7
    setPort(0, 1, 32'h24, 0, 3); setPort(1, 1, 32'h24, 4, 4); step("R6");
    rd2(32'h24, 32'h90, "R6");
    // R7: control bit 0 only; lowest port wins
    wr(0, 32'h00, 32'hFFFF_FFFF, 1, 32'h00); step("R7");
    rd2(32'h00, 32'h00, "R7");
    setPort(0, 1, 32'h00, 0, 1); setPort(1, 1, 32'h00, 1, 2); step("R7");
    rd2(32'h00, 32'h00, "R7");
    // R9: partial clear of bit 1
    wr(0, 32'h90, 32'h0002, 1, 32'h90); step("R9");
    rd2(32'h90, 32'h90, "R9");
    // R9: release by master 6 of sem 9 with simultaneous clear-all; set wins
    setPort(0, 1, 32'h2C, 0, 6); setPort(1, 1, 32'h90, 32'hFFFF, 2); step("R9");
    rd2(32'h90, 32'h2C, "R9");
    wr(1, 32'h90, 32'hFFFF, 2, 32'h90); step("R9");
    rd2(32'h90, 32'h90, "R9");
    // R10: reads only leave state alone
    for (int k = 0; k < 40; k++) rd2(8 + 4 * (k % 32), 32'h90, "R10");
    // R11: random traffic, both ports, checked each cycle
    for (int k = 0; k < 3000; k++) begin
      for (int p = 0; p < NP; p++) begin
        int sel = int'($urandom_range(0, 7));
        int addr = (sel < 5) ? 8 + 4 * sel : (sel == 5 ? 0 : (sel == 6 ? 32'h90 : 32'h88));
        int mid = int'($urandom_range(1, 3));
        int data = ($urandom_range(0, 1) == 1) ? mid : (sel == 6 ? int'($urandom_range(0, 65535)) : 0);
        setPort(p, $urandom_range(0, 2) != 0, addr, data, mid);
      end
      step("R11");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule